// File: doc/BRIEF.md
# Write-Through Snoopy Line Controller

This block is the coherence controller of a small private cache that writes every store straight through to a shared snooping bus and never allocates on a store. It takes one processor request at a time. A load that finds its line present is answered from the local array. A load that misses fetches the word over the bus and installs it. Every store goes out as a bus write. A store that hits also refreshes the local copy at the moment the bus accepts it, so the cache and memory always hold the same value.

Each line is either present or absent. The controller watches the writes that other caches put on the bus. A foreign write to an address it holds drops that line. A foreign write to the address of its own outstanding load marks that load as stale. The returning data is then thrown away and the load is issued again. Every bus master carries an identifier, and the controller ignores bus activity that carries its own identifier.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is absent, `cpu_ready` is 1, and `bus_req` and `rsp_valid` are 0.
- R2: A load that misses raises `bus_req` with `bus_cmd`=0 (read) and the load address on the cycle after it is accepted. One cycle after `bus_rvalid`, `rsp_valid` is 1 with the returned data, and the line is present from then on.
- R3: A load that hits answers on the next cycle with `rsp_valid`=1 and the stored data, and raises no bus request.
- R4: Every store raises `bus_req` with `bus_cmd`=1 (write), the address and the data, whether it hits or misses. It is acknowledged by `rsp_valid`=1 one cycle after the grant, and the presence of the line does not change.
- R5: A store that misses does not allocate, so a later load to that address still misses.
- R6: A store that hits writes its data into the local line in the grant cycle, so a later load hit returns the stored value.
- R7: A bus write seen on the snoop port from another master (`snp_mid` differs from the controller's own identifier) to an address whose line is present makes that line absent. A snooped write to another tag at the same index has no effect.
- R8: Snooped writes that carry the controller's own identifier, and snooped reads from any master, change no line.
- R9: A foreign snooped write to the address of an outstanding load, seen while the load waits for its grant or for its data, causes the returned data to be discarded with no response. The bus read is then issued again, and the response carries the data from the repeated read.
- R10: `cpu_ready` is 1 only while no request is in progress, and it is never 1 while `bus_req` is 1.
- R11: While `bus_req` is 1 and `bus_gnt` is 0, the request, command, address and write data stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address of the request |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Controller is idle and can take a request |
| rsp_valid | output | 1 | One-cycle completion pulse for a load or a store |
| rsp_data | output | DW | Load data, valid with `rsp_valid` after a load |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 1 | 0 = bus read, 1 = bus write |
| bus_addr | output | AW | Bus transaction address |
| bus_wdata | output | DW | Bus write data |
| bus_gnt | input | 1 | Grant; the transaction is issued on a cycle with `bus_req` and `bus_gnt` both 1 |
| bus_rvalid | input | 1 | Read data return for the outstanding bus read |
| bus_rdata | input | DW | Returned read data |
| snp_valid | input | 1 | An observed bus transaction is present |
| snp_we | input | 1 | Observed transaction is a write |
| snp_addr | input | AW | Observed address |
| snp_mid | input | MID_W | Identifier of the master that issued the observed transaction |

## Verification
The assertions assume that the bus only grants while `bus_req` is high, that `bus_rvalid` comes only while a read has been granted and not yet answered, that every snoop pulse lasts one cycle, and that `cpu_req` is raised only while `cpu_ready` is 1. The bench drives all stimulus from tasks that follow these rules: a miss is granted, data returns one or more cycles later, and snoop pulses are placed before the grant, between grant and data, or in the same cycle as the data. A behavioural model made of per-index presence, tag and data tables and an associative memory predicts every response, and the request and ready lines are compared with the model on every clock.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR_REQ  = 2'd3
  } ctl_state_t;

  localparam logic CMD_READ  = 1'b0;
  localparam logic CMD_WRITE = 1'b1;

endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int LINES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               lk_addr,
  output logic                        lk_hit,
  output logic [DW-1:0]               lk_data,
  input  logic [AW-1:0]               snp_addr,
  output logic                        snp_hit,
  input  logic                        inv_en,
  input  logic                        fill_en,
  input  logic [AW-1:0]               fill_addr,
  input  logic [DW-1:0]               fill_data,
  input  logic                        upd_en,
  input  logic [$clog2(LINES)-1:0]    upd_idx,
  input  logic [DW-1:0]               upd_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - IDX_W;

  logic [LINES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  logic [IDX_W-1:0] lk_idx, snp_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, snp_tag;

  assign lk_idx   = lk_addr[IDX_W-1:0];
  assign lk_tag   = lk_addr[AW-1:IDX_W];
  assign snp_idx  = snp_addr[IDX_W-1:0];
  assign snp_tag  = snp_addr[AW-1:IDX_W];
  assign fill_idx = fill_addr[IDX_W-1:0];

  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data = dat_q[lk_idx];
  assign snp_hit = vld_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

  // presence next state: a fill wins over an invalidation of the old line
  always_comb begin
    vld_d = vld_q;
    if (inv_en)  vld_d[snp_idx]  = 1'b0;
    if (fill_en) vld_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_addr[AW-1:IDX_W];
      dat_q[fill_idx] <= fill_data;
    end else if (upd_en) begin
      dat_q[upd_idx] <= upd_data;
    end
  end

  // R2
  fill_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(fill_idx)]);

endmodule

// File: rtl/wt_snoop_filter.sv
module wt_snoop_filter #(
  parameter int AW    = 12,
  parameter int MID_W = 2,
  parameter int MY_ID = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic             snp_we,
  input  logic [AW-1:0]    snp_addr,
  input  logic [MID_W-1:0] snp_mid,
  input  logic             snp_hit,
  input  logic             pend_rd,
  input  logic [AW-1:0]    pend_addr,
  output logic             inv_en,
  output logic             kill_hit
);

  localparam logic [MID_W-1:0] OWN_ID = MID_W'(MY_ID);

  logic foreign_wr;

  assign foreign_wr = snp_valid && snp_we && (snp_mid != OWN_ID);
  assign inv_en     = foreign_wr && snp_hit;
  assign kill_hit   = foreign_wr && pend_rd && (snp_addr == pend_addr);

  // R8
  own_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_mid == OWN_ID || !snp_we)) |-> (!inv_en && !kill_hit));

endmodule

// File: rtl/wt_line_ctl.sv
module wt_line_ctl #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          lk_hit,
  input  logic [DW-1:0] lk_data,
  output logic          bus_req,
  output logic          bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_rvalid,
  input  logic [DW-1:0] bus_rdata,
  input  logic          kill_hit,
  output logic          pend_rd,
  output logic [AW-1:0] req_addr,
  output logic          fill_en,
  output logic          upd_en
);

  import wt_snoop_pkg::*;

  ctl_state_t    state_q, state_d;
  logic          kill_q, kill_d;
  logic          rsp_v_q, rsp_v_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          addr_en, rdata_en;
  logic          kill_now;

  assign kill_now = kill_q || kill_hit;

  always_comb begin
    state_d  = state_q;
    kill_d   = kill_q;
    rsp_v_d  = 1'b0;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    rdata_d  = rdata_q;
    addr_en  = 1'b0;
    rdata_en = 1'b0;
    fill_en  = 1'b0;
    upd_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (cpu_we) begin
            state_d = ST_WR_REQ;
            addr_d  = cpu_addr;
            wdata_d = cpu_wdata;
            addr_en = 1'b1;
          end else if (lk_hit) begin
            rsp_v_d  = 1'b1;
            rdata_d  = lk_data;
            rdata_en = 1'b1;
          end else begin
            state_d = ST_RD_REQ;
            addr_d  = cpu_addr;
            addr_en = 1'b1;
            kill_d  = 1'b0;
          end
        end
      end
      ST_RD_REQ: begin
        kill_d = kill_now;
        if (bus_gnt) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        kill_d = kill_now;
        if (bus_rvalid) begin
          kill_d = 1'b0;
          if (kill_now) begin
            state_d = ST_RD_REQ;
          end else begin
            fill_en  = 1'b1;
            rsp_v_d  = 1'b1;
            rdata_d  = bus_rdata;
            rdata_en = 1'b1;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_WR_REQ: begin
        if (bus_gnt) begin
          upd_en  = lk_hit;
          rsp_v_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kill_q  <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      kill_q  <= kill_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
    if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_ready = (state_q == ST_IDLE);
  assign bus_req   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign bus_cmd   = (state_q == ST_WR_REQ) ? CMD_WRITE : CMD_READ;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rdata_q;
  assign pend_rd   = (state_q == ST_RD_REQ) || (state_q == ST_RD_WAIT);
  assign req_addr  = addr_q;

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_wdata)));

  // R4
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == CMD_WRITE) |=> (rsp_valid && cpu_ready));

  // R3
  rd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && !cpu_we && lk_hit) |=> (rsp_valid && !bus_req));

  // R9
  retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_WAIT && bus_rvalid && kill_now) |=> (bus_req && !rsp_valid && bus_cmd == CMD_READ));

  // R10
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req);

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int LINES = 8,
  parameter int MID_W = 2,
  parameter int MY_ID = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ready,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             bus_req,
  output logic             bus_cmd,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_gnt,
  input  logic             bus_rvalid,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             snp_valid,
  input  logic             snp_we,
  input  logic [AW-1:0]    snp_addr,
  input  logic [MID_W-1:0] snp_mid
);

  localparam int IDX_W = $clog2(LINES);

  logic          lk_hit, snp_hit, inv_en, kill_hit, pend_rd;
  logic          fill_en, upd_en;
  logic [DW-1:0] lk_data;
  logic [AW-1:0] req_addr, lk_addr;

  // idle: look up the incoming request; busy: look up the held one
  assign lk_addr = cpu_ready ? cpu_addr : req_addr;

  wt_line_ctl #(.AW(AW), .DW(DW)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .lk_hit     (lk_hit),
    .lk_data    (lk_data),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_gnt    (bus_gnt),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .kill_hit   (kill_hit),
    .pend_rd    (pend_rd),
    .req_addr   (req_addr),
    .fill_en    (fill_en),
    .upd_en     (upd_en)
  );

  wt_line_store #(.AW(AW), .DW(DW), .LINES(LINES)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .snp_addr  (snp_addr),
    .snp_hit   (snp_hit),
    .inv_en    (inv_en),
    .fill_en   (fill_en),
    .fill_addr (req_addr),
    .fill_data (bus_rdata),
    .upd_en    (upd_en),
    .upd_idx   (req_addr[IDX_W-1:0]),
    .upd_data  (bus_wdata)
  );

  wt_snoop_filter #(.AW(AW), .MID_W(MID_W), .MY_ID(MY_ID)) i_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_valid (snp_valid),
    .snp_we    (snp_we),
    .snp_addr  (snp_addr),
    .snp_mid   (snp_mid),
    .snp_hit   (snp_hit),
    .pend_rd   (pend_rd),
    .pend_addr (req_addr),
    .inv_en    (inv_en),
    .kill_hit  (kill_hit)
  );

endmodule

// File: tb/test_wt_snoop_cache.sv
`timescale 1ns/1ps
module test_wt_snoop_cache;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MYID = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          bus_req, bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt, bus_rvalid;
  logic [DW-1:0] bus_rdata;
  logic          snp_valid, snp_we;
  logic [AW-1:0] snp_addr;
  logic [1:0]    snp_mid;

  always #2 clk = ~clk;

  wt_snoop_cache #(.AW(AW), .DW(DW), .LINES(8), .MID_W(2), .MY_ID(MYID)) i_wt_snoop_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr), .snp_mid(snp_mid)
  );

  int checks = 0;
  int errors = 0;
  bit mon_en = 0;
  bit exp_req = 0;
  bit exp_rdy = 1;

  // behavioural model: presence, tag and data per index, plus memory
  bit            m_vld [8];
  logic [8:0]    m_tag [8];
  logic [DW-1:0] m_dat [8];
  logic [DW-1:0] mem [int];

  function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return DW'(a) * 16'd7 + 16'h31;
  endfunction

  function automatic bit m_hit(logic [AW-1:0] a);
    return m_vld[a[2:0]] && (m_tag[a[2:0]] == a[11:3]);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of request and ready lines with the model
  always @(posedge clk) begin
    if (mon_en) begin
      checks++;
      if (bus_req !== exp_req || cpu_ready !== exp_rdy) begin
        errors++;
        $display("FAIL R10 per-clock req/ready: actual=%0b%0b expected=%0b%0b",
                 bus_req, cpu_ready, exp_req, exp_rdy);
      end
    end
  end

  task automatic do_read(logic [AW-1:0] a, string miss_lbl);
    bit hit = m_hit(a);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 0;
    if (hit) begin
      chk(rsp_valid === 1'b1, "R3", "hit rsp_valid", int'(rsp_valid), 1);
      chk(rsp_data === m_dat[a[2:0]], "R3", "hit data", int'(rsp_data), int'(m_dat[a[2:0]]));
    end else begin
      exp_req = 1; exp_rdy = 0;
      chk(bus_req === 1'b1 && bus_cmd === 1'b0 && bus_addr === a && rsp_valid === 1'b0,
          miss_lbl, "miss bus read", int'(bus_addr), int'(a));
      bus_gnt = 1;
      @(negedge clk);
      bus_gnt = 0; exp_req = 0;
      @(negedge clk);
      bus_rvalid = 1; bus_rdata = memval(a);
      @(negedge clk);
      bus_rvalid = 0; exp_rdy = 1;
      chk(rsp_valid === 1'b1 && rsp_data === memval(a), miss_lbl, "fill response",
          int'(rsp_data), int'(memval(a)));
      m_vld[a[2:0]] = 1; m_tag[a[2:0]] = a[11:3]; m_dat[a[2:0]] = memval(a);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, int gnt_delay);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0; exp_req = 1; exp_rdy = 0;
    chk(bus_req === 1'b1 && bus_cmd === 1'b1 && bus_addr === a && bus_wdata === d,
        "R4", "bus write", int'(bus_wdata), int'(d));
    for (int k = 0; k < gnt_delay; k++) begin
      @(negedge clk);
      chk(bus_req === 1'b1 && bus_cmd === 1'b1 && bus_addr === a && bus_wdata === d,
          "R11", "held request", int'(bus_addr), int'(a));
    end
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0; exp_req = 0; exp_rdy = 1;
    chk(rsp_valid === 1'b1, "R4", "write ack", int'(rsp_valid), 1);
    mem[int'(a)] = d;
    if (m_hit(a)) m_dat[a[2:0]] = d;
  endtask

  task automatic model_snoop(logic [AW-1:0] a, logic [1:0] mid, bit we, logic [DW-1:0] d);
    if (we && mid != 2'(MYID)) begin
      mem[int'(a)] = d;
      if (m_hit(a)) m_vld[a[2:0]] = 0;
    end
  endtask

  task automatic set_snoop(logic [AW-1:0] a, logic [1:0] mid, bit we, logic [DW-1:0] d);
    snp_valid = 1; snp_we = we; snp_addr = a; snp_mid = mid;
    model_snoop(a, mid, we, d);
  endtask

  task automatic do_snoop(logic [AW-1:0] a, logic [1:0] mid, bit we, logic [DW-1:0] d);
    set_snoop(a, mid, we, d);
    @(negedge clk);
    snp_valid = 0;
  endtask

  // phase 0: snoop before grant; 1: between grant and data; 2: with the data
  task automatic retry_read(logic [AW-1:0] a, logic [DW-1:0] nd, int phase);
    logic [DW-1:0] stale = memval(a);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 0; exp_req = 1; exp_rdy = 0;
    chk(bus_req === 1'b1 && bus_cmd === 1'b0 && bus_addr === a, "R9", "first read",
        int'(bus_addr), int'(a));
    if (phase == 0) set_snoop(a, 2'd2, 1'b1, nd);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0; exp_req = 0; snp_valid = 0;
    if (phase == 1) begin
      set_snoop(a, 2'd3, 1'b1, nd);
      @(negedge clk);
      snp_valid = 0;
    end
    bus_rvalid = 1; bus_rdata = stale;
    if (phase == 2) set_snoop(a, 2'd0, 1'b1, nd);
    @(negedge clk);
    bus_rvalid = 0; snp_valid = 0; exp_req = 1;
    chk(rsp_valid === 1'b0 && bus_req === 1'b1 && bus_cmd === 1'b0, "R9", "stale fill dropped",
        int'(rsp_valid), 0);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0; exp_req = 0;
    @(negedge clk);
    bus_rvalid = 1; bus_rdata = nd;
    @(negedge clk);
    bus_rvalid = 0; exp_rdy = 1;
    chk(rsp_valid === 1'b1 && rsp_data === nd, "R9", "retried data", int'(rsp_data), int'(nd));
    m_vld[a[2:0]] = 1; m_tag[a[2:0]] = a[11:3]; m_dat[a[2:0]] = nd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; bus_rvalid = 0; bus_rdata = '0;
    snp_valid = 0; snp_we = 0; snp_addr = '0; snp_mid = '0;
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    chk(cpu_ready === 1'b1 && bus_req === 1'b0 && rsp_valid === 1'b0, "R1", "reset outputs",
        int'({cpu_ready, bus_req, rsp_valid}), 4);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    chk(cpu_ready === 1'b1 && bus_req === 1'b0, "R1", "after release",
        int'({cpu_ready, bus_req}), 2);

    // R1: lines start absent, so the first load misses
    do_read(12'h010, "R1");
    do_read(12'h010, "R2");
    do_read(12'h010, "R3");
    // R6: write hit refreshes local copy
    do_write(12'h010, 16'hBEEF, 0);
    do_read(12'h010, "R6");
    chk(m_hit(12'h010) && m_dat[0] == 16'hBEEF, "R6", "model agrees", int'(m_dat[0]), 16'hBEEF);
    // R5: write miss, then load misses
    do_write(12'h123, 16'h1234, 2);
    chk(!m_hit(12'h123), "R5", "no allocate in model", 0, 0);
    do_read(12'h123, "R5");
    // R7: foreign write invalidates; different tag same index does not
    do_snoop(12'h018, 2'd2, 1'b1, 16'h7777);
    do_read(12'h010, "R7");
    do_snoop(12'h010, 2'd0, 1'b1, 16'h5A5A);
    do_read(12'h010, "R7");
    chk(rsp_data === 16'h5A5A, "R7", "refetched value", int'(rsp_data), 16'h5A5A);
    // R8: own-ID write and foreign read do nothing
    do_snoop(12'h010, 2'(MYID), 1'b1, 16'h0);
    do_snoop(12'h010, 2'd3, 1'b0, 16'h0);
    do_read(12'h010, "R8");
    chk(rsp_data === 16'h5A5A, "R8", "line kept", int'(rsp_data), 16'h5A5A);
    // R4: write miss with long grant delay, state unchanged
    do_write(12'h2A5, 16'hC0DE, 4);
    do_read(12'h2A5, "R4");
    // R9: stale fills
    retry_read(12'h044, 16'h4401, 0);
    retry_read(12'h045, 16'h4502, 1);
    retry_read(12'h046, 16'h4603, 2);
    do_read(12'h046, "R9");
    // mixed pattern
    for (int i = 0; i < 60; i++) begin
      int r = (i * 37 + 11) % 97;
      logic [AW-1:0] a = AW'(((r >> 2) % 3) * 64 + (r % 4));
      case (r % 5)
        0, 1: do_read(a, "R2");
        2: do_write(a, DW'(r * 13 + i), i % 3);
        3: do_snoop(a, 2'd2, 1'b1, DW'(r * 5 + 1));
        default: do_snoop(a, 2'(MYID), 1'b1, DW'(r));
      endcase
    end
    repeat (2) @(negedge clk);
    mon_en = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule